// File: doc/BRIEF.md
# Multi-Mode Inversion Link Encoder

This block sits on the transmit side of a network-on-chip link. Each accepted flit is first turned into its reflected binary (Gray) form. The encoder then builds four candidate link words from that Gray word: the word unchanged, the word with its odd-indexed lanes flipped, the word with its even-indexed lanes flipped, and the word with every lane flipped. Each candidate is compared with the word that was last put on the link.

For every candidate, each pair of neighbouring lanes is sorted into one of four coupling classes. A ones-counter tallies each class. A decision stage weighs the four tallies with integer weights, giving one cost per candidate, and picks the cheapest allowed candidate. The chosen word goes onto the link with a 2-bit code that tells the far end which flip was applied. A parameter can remove even-lane flipping, which leaves only none, odd and full.

Top module: `linkinv_encoder`

## Requirements
- R1: A flit accepted with `inValid` high appears on `linkData`/`linkMode` after exactly one rising clock edge, and `linkValid` is high for that one cycle.
- R2: The data path works on the Gray form of the input: bit i is `inData[i] ^ inData[i+1]`, and the top bit is copied unchanged. With `linkMode` = 00 the link word equals this Gray word.
- R3: The `linkMode` code gives the applied flip. 00 means none. 01 flips bits 1, 3, 5, … . 10 flips bits 0, 2, 4, … . 11 flips every bit.
- R4: Each adjacent lane pair (i, i+1) is classified against the previous link word. Class 1: exactly one lane toggles. Class 2: both toggle in opposite directions. Class 3: both toggle in the same direction. Class 4: neither toggles. A candidate's cost is K1·n1 + K2·n2 + K3·n3 + K4·n4. The defaults are K1=2, K2=4, K3=1, K4=0.
- R5: The candidate with the lowest cost is sent. When costs are equal, the first candidate in the order none, odd, even, full wins.
- R6: With `EVEN_EN` = 0 the code 10 is never produced, and the choice is made among none, odd and full only.
- R7: The previous-word reference is the word actually transmitted, after any flip. It is zero after reset, and it changes only when a flit is accepted.
- R8: In a cycle with no accepted flit, `linkValid` is low on the next cycle and `linkData`/`linkMode` keep their values.
- R9: While reset is held and afterwards until the first flit, `linkValid`, `linkData` and `linkMode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Flit on `inData` is accepted this cycle |
| inData | input | LINK_W-1 | Binary flit payload |
| linkValid | output | 1 | Link word is new this cycle |
| linkData | output | LINK_W-1 | Encoded link word |
| linkMode | output | 2 | Flip code applied to `linkData` |

## Verification
The only state is the transmitted-word register. If it holds a wrong value, the class tallies for the very next flit are computed against the wrong reference. That shows up one cycle later as a different `linkMode` or a different `linkData` than the cost rule predicts. The scoreboard keeps its own copy of the previous word for a full-mode instance and a reduced-mode instance, so a wrong reference, a swapped lane mask, a broken tie order or a leaked even choice each appears as a mismatch on the first affected flit. Idle gaps between flits check that the reference and outputs do not drift when nothing is accepted.

// File: rtl/linkinv_pkg.sv
package linkinv_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_ODD  = 2'b01,
    MODE_EVEN = 2'b10,
    MODE_FULL = 2'b11
  } invMode_t;

  localparam int NUM_CAND  = 4;
  localparam int NUM_CLASS = 4;

  typedef struct packed {
    logic     loadEn;
    invMode_t mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/linkinv_pairclass.sv
module linkinv_pairclass #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic [DATA_W-1:0]          prevWord,
  input  logic [DATA_W-1:0]          candWord,
  output logic [3:0][CNT_W-1:0]      classCnt
);
  localparam int PAIRS = DATA_W - 1;

  logic [PAIRS-1:0] isOne, isOpp, isSame, isQuiet;

  genvar p;
  generate
    for (p = 0; p < PAIRS; p++) begin : g_pair
      logic swLo, swHi, wasSplit;
      assign swLo     = prevWord[p] ^ candWord[p];
      assign swHi     = prevWord[p+1] ^ candWord[p+1];
      assign wasSplit = prevWord[p] ^ prevWord[p+1];
      assign isOne[p]   = swLo ^ swHi;
      assign isOpp[p]   = swLo & swHi & wasSplit;
      assign isSame[p]  = swLo & swHi & ~wasSplit;
      assign isQuiet[p] = ~(swLo | swHi);
    end
  endgenerate

  function automatic logic [CNT_W-1:0] onesOf(input logic [PAIRS-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PAIRS; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  always_comb begin
    classCnt[0] = onesOf(isOne);
    classCnt[1] = onesOf(isOpp);
    classCnt[2] = onesOf(isSame);
    classCnt[3] = onesOf(isQuiet);
  end

endmodule

// File: rtl/linkinv_datapath.sv
module linkinv_datapath
  import linkinv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [DATA_W-1:0]                     inData,
  input  ctrlStrobe_t                           strobe,
  output logic [NUM_CAND-1:0][3:0][CNT_W-1:0]   candCnt,
  output logic                                  linkValid,
  output logic [DATA_W-1:0]                     linkData,
  output logic [1:0]                            linkMode
);

  function automatic logic [DATA_W-1:0] laneMask(input logic oddLanes);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i % 2) == 1) == oddLanes;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD_MASK  = laneMask(1'b1);
  localparam logic [DATA_W-1:0] EVEN_MASK = laneMask(1'b0);

  logic [DATA_W-1:0] grayWord;
  logic [DATA_W-1:0] sentWord;
  logic [NUM_CAND-1:0][DATA_W-1:0] candWord;
  logic validQ;
  logic [1:0] modeQ;

  assign grayWord = inData ^ (inData >> 1);

  assign candWord[MODE_NONE] = grayWord;
  assign candWord[MODE_ODD]  = grayWord ^ ODD_MASK;
  assign candWord[MODE_EVEN] = grayWord ^ EVEN_MASK;
  assign candWord[MODE_FULL] = ~grayWord;

  genvar c;
  generate
    for (c = 0; c < NUM_CAND; c++) begin : g_cand
      linkinv_pairclass #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_class (
        .prevWord (sentWord),
        .candWord (candWord[c]),
        .classCnt (candCnt[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentWord <= '0;
      modeQ    <= '0;
      validQ   <= 1'b0;
    end else begin
      validQ <= strobe.loadEn;
      if (strobe.loadEn) begin
        sentWord <= candWord[strobe.mode];
        modeQ    <= strobe.mode;
      end
    end
  end

  assign linkValid = validQ;
  assign linkData  = sentWord;
  assign linkMode  = modeQ;

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> (!linkValid && $stable(linkData) && $stable(linkMode)));

  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> linkValid);

  assert_plain_gray_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.mode == MODE_NONE) |=> (linkData == $past(grayWord)));

  assert_full_flip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.mode == MODE_FULL) |=> (linkData == ~$past(grayWord)));

endmodule

// File: rtl/linkinv_control.sv
module linkinv_control
  import linkinv_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int WT_W    = 8,
  parameter bit EVEN_EN = 1'b1,
  parameter int K1      = 2,
  parameter int K2      = 4,
  parameter int K3      = 1,
  parameter int K4      = 0
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  inValid,
  input  logic [NUM_CAND-1:0][3:0][CNT_W-1:0]   candCnt,
  output ctrlStrobe_t                           strobe
);
  localparam int COST_W = CNT_W + WT_W + 2;

  logic [NUM_CAND-1:0][COST_W-1:0] candCost;
  logic [COST_W-1:0] bestCost;
  invMode_t bestMode;

  genvar c;
  generate
    for (c = 0; c < NUM_CAND; c++) begin : g_cost
      assign candCost[c] = COST_W'(K1) * COST_W'(candCnt[c][0])
                         + COST_W'(K2) * COST_W'(candCnt[c][1])
                         + COST_W'(K3) * COST_W'(candCnt[c][2])
                         + COST_W'(K4) * COST_W'(candCnt[c][3]);
    end
  endgenerate

  always_comb begin
    bestMode = MODE_NONE;
    bestCost = candCost[MODE_NONE];
    for (int i = 1; i < NUM_CAND; i++) begin
      if ((EVEN_EN || i != int'(MODE_EVEN)) && candCost[i] < bestCost) begin
        bestMode = invMode_t'(i);
        bestCost = candCost[i];
      end
    end
  end

  assign strobe.loadEn = inValid;
  assign strobe.mode   = bestMode;

  assert_not_worse_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (bestCost <= candCost[MODE_NONE] && bestCost <= candCost[MODE_FULL]));

  assert_no_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !EVEN_EN) |-> (strobe.mode != MODE_EVEN));

endmodule

// File: rtl/linkinv_encoder.sv
module linkinv_encoder
  import linkinv_pkg::*;
#(
  parameter int LINK_W  = 9,
  parameter bit EVEN_EN = 1'b1,
  parameter int WT_W    = 8,
  parameter int K1      = 2,
  parameter int K2      = 4,
  parameter int K3      = 1,
  parameter int K4      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [LINK_W-2:0] inData,
  output logic              linkValid,
  output logic [LINK_W-2:0] linkData,
  output logic [1:0]        linkMode
);
  localparam int DATA_W = LINK_W - 1;
  localparam int CNT_W  = $clog2(DATA_W);

  ctrlStrobe_t strobe;
  logic [NUM_CAND-1:0][3:0][CNT_W-1:0] candCnt;

  linkinv_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .strobe    (strobe),
    .candCnt   (candCnt),
    .linkValid (linkValid),
    .linkData  (linkData),
    .linkMode  (linkMode)
  );

  linkinv_control #(
    .CNT_W(CNT_W), .WT_W(WT_W), .EVEN_EN(EVEN_EN),
    .K1(K1), .K2(K2), .K3(K3), .K4(K4)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .candCnt (candCnt),
    .strobe  (strobe)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rstN |=> (!linkValid && linkData == '0 && linkMode == 2'b00));

endmodule

// File: tb/linkinv_encoder_bench.sv
module linkinv_encoder_bench;
  localparam int DW = 8;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [1:0]    mode;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;

  logic          vFull, vRed;
  logic [DW-1:0] dFull, dRed;
  logic [1:0]    mFull, mRed;

  int checks = 0;
  int fails  = 0;

  item_t qFull[$];
  item_t qRed[$];
  logic [DW-1:0] prevFull = '0;
  logic [DW-1:0] prevRed  = '0;
  logic          seenFull = 1'b0;
  item_t         lastFull;

  always #2 clk = ~clk;

  linkinv_encoder #(.LINK_W(DW+1), .EVEN_EN(1'b1), .K1(2), .K2(4), .K3(1), .K4(0))
  u_linkinv_encoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .linkValid(vFull), .linkData(dFull), .linkMode(mFull)
  );

  linkinv_encoder #(.LINK_W(DW+1), .EVEN_EN(1'b0), .K1(2), .K2(4), .K3(1), .K4(0))
  u_linkinv_encoder_red (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .linkValid(vRed), .linkData(dRed), .linkMode(mRed)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: Gray form; R3: lane flips per code
  function automatic logic [DW-1:0] flipWord(input logic [DW-1:0] g, input int code);
    logic [DW-1:0] r;
    r = g;
    for (int i = 0; i < DW; i++) begin
      if (code == 3) r[i] = ~g[i];
      else if (code == 1 && (i % 2) == 1) r[i] = ~g[i];
      else if (code == 2 && (i % 2) == 0) r[i] = ~g[i];
    end
    return r;
  endfunction

  // R4: pair classes and weighted cost
  function automatic int costOf(input logic [DW-1:0] pv, input logic [DW-1:0] cw);
    int total;
    total = 0;
    for (int i = 0; i < DW-1; i++) begin
      bit a, b;
      a = pv[i] != cw[i];
      b = pv[i+1] != cw[i+1];
      if (a && b) total += (cw[i] != cw[i+1]) ? 4 : 1;
      else if (a || b) total += 2;
    end
    return total;
  endfunction

  // R5 tie order, R6 reduced set
  function automatic item_t predict(input logic [DW-1:0] pv, input logic [DW-1:0] d, input bit evenOk);
    logic [DW-1:0] g;
    item_t it;
    int best;
    g = d;
    for (int i = 0; i < DW-1; i++) g[i] = d[i] ^ d[i+1];
    it.mode = 2'd0;
    it.data = g;
    best = costOf(pv, g);
    for (int code = 1; code < 4; code++) begin
      if (code == 2 && !evenOk) continue;
      if (costOf(pv, flipWord(g, code)) < best) begin
        best = costOf(pv, flipWord(g, code));
        it.mode = 2'(code);
        it.data = flipWord(g, code);
      end
    end
    return it;
  endfunction

  task automatic send(input logic [DW-1:0] d);
    item_t a, b;
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    a = predict(prevFull, d, 1'b1);
    b = predict(prevRed, d, 1'b0);
    qFull.push_back(a);
    qRed.push_back(b);
    prevFull = a.data; // R7: reference is the sent word
    prevRed  = b.data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = ~inData; // ignored while idle (R8)
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (vFull) begin
        item_t e;
        if (qFull.size() == 0) check(1'b0, "R1 unexpected output", 32'(dFull), 0);
        else begin
          e = qFull.pop_front();
          check(dFull == e.data, "R2/R3/R5 data", 32'(dFull), 32'(e.data));
          check(mFull == e.mode, "R4/R5 mode", 32'(mFull), 32'(e.mode));
        end
        lastFull = '{data: dFull, mode: mFull};
        seenFull = 1'b1;
      end else if (seenFull) begin
        check(dFull == lastFull.data && mFull == lastFull.mode, "R8 hold",
              32'({dFull, mFull}), 32'({lastFull.data, lastFull.mode}));
      end
      if (vRed) begin
        item_t e;
        if (qRed.size() == 0) check(1'b0, "R6 unexpected output", 32'(dRed), 0);
        else begin
          e = qRed.pop_front();
          check(dRed == e.data, "R6 data", 32'(dRed), 32'(e.data));
          check(mRed == e.mode && mRed != 2'b10, "R6 mode", 32'(mRed), 32'(e.mode));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!vFull && dFull == '0 && mFull == 2'b00, "R9 reset state",
          32'({vFull, dFull, mFull}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!vFull && dFull == '0 && mFull == 2'b00, "R9 after reset",
          32'({vFull, dFull, mFull}), 0);
    // R2: zero input against zero reference stays plain
    send(8'h00);
    // R3/R5: Gray word all ones, full flip wins from zero reference
    send(8'hAA);
    // R7: idle gap must not move reference
    idle(3);
    send(8'h55);
    send(8'hFF);
    send(8'h0F);
    idle(2);
    send(8'h33);
    send(8'hCC);
    // mixed patterns
    for (int k = 0; k < 400; k++) begin
      send(8'($urandom));
      if (k % 37 == 0) idle(1);
    end
    idle(4);
    check(qFull.size() == 0, "R1 drained", 32'(qFull.size()), 0);
    check(qRed.size() == 0, "R6 drained", 32'(qRed.size()), 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule